// File: doc/BRIEF.md
# Two-Phase Fetch Sequencer with PC-Relative Branch

This block runs the instruction sequence of a small processor core. It keeps a program counter and an instruction register. It steps through two phases: a fetch phase and an execute phase. In fetch it presents the program counter as a read address and waits for memory to signal that the word is ready. On that cycle it latches the word into the instruction register and moves to execute.

Execute lasts one cycle. In that cycle the program counter moves on by the instruction size. If the decoder outside this block asks for a branch and the condition "result greater than zero" holds, the counter instead takes a target. The target is the already-advanced address plus a sign-extended offset, so a loop that branches back from the last of four instructions uses an offset of minus sixteen. The condition is derived from a zero flag and a negative flag: both must be clear.

Decoding the instruction and the datapath sit outside this block. The decoder reads the instruction register and drives the branch request and offset during execute.

Top module: `fetch_seq`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, the program counter equals START_ADDR, the block is in fetch (exec_phase low, mem_rd_req high) and the instruction register reads zero.
- R2: In fetch, while mem_rdy is low, the block stays in fetch and neither the program counter nor the instruction register changes, whatever the branch inputs carry.
- R3: In fetch, the clock edge on which mem_rdy is high loads mem_rdata into the instruction register, and exec_phase is high from the next cycle.
- R4: Execute lasts exactly one cycle, after which the block is back in fetch.
- R5: At the end of an execute cycle with br_req low, the program counter increases by INSTR_BYTES (4 by default).
- R6: At the end of an execute cycle with br_req high, flag_z low and flag_n low, the program counter becomes the old value plus INSTR_BYTES plus br_off sign-extended from OFF_W bits. A negative offset gives a target before the branch.
- R7: At the end of an execute cycle with br_req high and either flag_z or flag_n high, the branch is not taken and the program counter increases by INSTR_BYTES.
- R8: mem_rd_req is high exactly in fetch, and mem_addr always equals pc_out.
- R9: In execute, mem_rdy and mem_rdata have no effect: the instruction register keeps its value.
- R10: Program counter arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside the block |
| mem_rdy | input | 1 | Memory signals that the read word is valid |
| mem_rdata | input | DATA_W | Instruction word returned by memory |
| br_req | input | 1 | Decoder asks for a conditional branch (sampled in execute) |
| br_off | input | OFF_W | Signed branch offset in bytes |
| flag_z | input | 1 | Zero flag of the last result |
| flag_n | input | 1 | Negative flag of the last result |
| mem_rd_req | output | 1 | Read request, high in fetch |
| mem_addr | output | ADDR_W | Read address, equal to the program counter |
| pc_out | output | ADDR_W | Current program counter |
| ir_out | output | DATA_W | Instruction register |
| exec_phase | output | 1 | High during the execute phase |

## Verification
The sequential advance and the branch redirect act on the same execute cycle. The target has to be built from the advanced address and not from the address of the branch. The bench provokes this by reproducing a four-instruction loop whose closing branch uses an offset of -16. A correct design returns to the loop head. A target built from the branch's own address would land four bytes early. Forward offsets and branches suppressed by each flag are judged the same way, by comparing pc_out with a value the bench computes itself.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [0:0] {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } phase_e;
endpackage

// File: rtl/fseq_rst_sync.sv
module fseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fseq_phase_ctl.sv
module fseq_phase_ctl
  import fseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mem_rdy,
  output logic cap_en,
  output logic adv_en,
  output logic in_exec
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_FETCH: if (mem_rdy) phase_d = PH_EXEC;
      PH_EXEC:  phase_d = PH_FETCH;
      default:  phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_FETCH;
    else        phase_q <= phase_d;
  end

  assign cap_en  = (phase_q == PH_FETCH) && mem_rdy;
  assign adv_en  = (phase_q == PH_EXEC);
  assign in_exec = (phase_q == PH_EXEC);
endmodule

// File: rtl/fseq_pc_unit.sv
module fseq_pc_unit #(
  parameter int              ADDR_W      = 32,
  parameter int              OFF_W       = 16,
  parameter int              INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  logic              br_req,
  input  logic [OFF_W-1:0]  br_off,
  input  logic              flag_z,
  input  logic              flag_n,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] pc_q, pc_d, pc_seq, off_ext;
  logic              cond_gt, take;

  // Greater than zero: neither zero nor negative.
  assign cond_gt = !flag_z && !flag_n;
  assign take    = br_req && cond_gt;

  generate
    if (EXT_W > 0) begin : g_ext
      assign off_ext = {{EXT_W{br_off[OFF_W-1]}}, br_off};
    end else begin : g_noext
      assign off_ext = br_off[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    pc_seq = pc_q + STEP;
    pc_d   = pc_q;
    if (adv_en) pc_d = take ? (pc_seq + off_ext) : pc_seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= START_ADDR;
    else if (adv_en) pc_q <= pc_d;
  end

  assign pc = pc_q;
endmodule

// File: rtl/fseq_ir_reg.sv
module fseq_ir_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ir
);
  logic [DATA_W-1:0] ir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ir_q <= '0;
    else if (cap_en) ir_q <= rdata;
  end

  assign ir = ir_q;
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int                ADDR_W      = 32,
  parameter int                DATA_W      = 32,
  parameter int                OFF_W       = 16,
  parameter int                INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] START_ADDR  = 32'd1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_rdy,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              br_req,
  input  logic [OFF_W-1:0]  br_off,
  input  logic              flag_z,
  input  logic              flag_n,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] ir_out,
  output logic              exec_phase
);
  logic rst_n_s, cap_en, adv_en, in_exec;
  logic [ADDR_W-1:0] pc;

  fseq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  fseq_phase_ctl u_phase (
    .clk(clk), .rst_n(rst_n_s), .mem_rdy(mem_rdy),
    .cap_en(cap_en), .adv_en(adv_en), .in_exec(in_exec)
  );

  fseq_pc_unit #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .INSTR_BYTES(INSTR_BYTES), .START_ADDR(START_ADDR)
  ) u_pc (
    .clk(clk), .rst_n(rst_n_s), .adv_en(adv_en), .br_req(br_req), .br_off(br_off),
    .flag_z(flag_z), .flag_n(flag_n), .pc(pc)
  );

  fseq_ir_reg #(.DATA_W(DATA_W)) u_ir (
    .clk(clk), .rst_n(rst_n_s), .cap_en(cap_en), .rdata(mem_rdata), .ir(ir_out)
  );

  assign pc_out     = pc;
  assign mem_addr   = pc;
  assign mem_rd_req = !in_exec;
  assign exec_phase = in_exec;
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int OFF_W       = 16,
  parameter int INSTR_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rdy,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              br_req,
  input logic [OFF_W-1:0]  br_off,
  input logic              flag_z,
  input logic              flag_n,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] pc_out,
  input logic [DATA_W-1:0] ir_out,
  input logic              exec_phase
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);
  logic [ADDR_W-1:0] off_x;
  assign off_x = ADDR_W'($signed(br_off));

  // R2
  fetch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_phase && !mem_rdy) |=> (!exec_phase && $stable(pc_out) && $stable(ir_out)));
  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_phase && mem_rdy) |=> (exec_phase && ir_out == $past(mem_rdata)));
  // R4
  exec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_phase |=> !exec_phase);
  // R5
  seq_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_phase && !br_req) |=> pc_out == $past(pc_out) + STEP);
  // R6
  br_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_phase && br_req && !flag_z && !flag_n) |=> pc_out == $past(pc_out) + STEP + $past(off_x));
  // R7
  br_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_phase && br_req && (flag_z || flag_n)) |=> pc_out == $past(pc_out) + STEP);
  // R8
  rd_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req != exec_phase) && (mem_addr == pc_out));
  // R9
  exec_hold_ir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_phase |=> $stable(ir_out));
endmodule

bind fetch_seq fseq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .INSTR_BYTES(INSTR_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rdy(mem_rdy), .mem_rdata(mem_rdata), .br_req(br_req),
  .br_off(br_off), .flag_z(flag_z), .flag_n(flag_n), .mem_rd_req(mem_rd_req),
  .mem_addr(mem_addr), .pc_out(pc_out), .ir_out(ir_out), .exec_phase(exec_phase)
);

// File: tb/fetch_seq_tb.sv
module fetch_seq_tb;
  localparam int AW = 32, DW = 32, OW = 16;
  localparam logic [AW-1:0] START = 32'd1000;

  logic clk = 1'b0;
  logic rst_n, mem_rdy, br_req, flag_z, flag_n;
  logic [DW-1:0] mem_rdata;
  logic [OW-1:0] br_off;
  logic mem_rd_req, exec_phase;
  logic [AW-1:0] mem_addr, pc_out;
  logic [DW-1:0] ir_out;
  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] exp_pc;

  always #4 clk = ~clk;

  fetch_seq #(.ADDR_W(AW), .DATA_W(DW), .OFF_W(OW), .START_ADDR(START)) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_rdy(mem_rdy), .mem_rdata(mem_rdata), .br_req(br_req),
    .br_off(br_off), .flag_z(flag_z), .flag_n(flag_n), .mem_rd_req(mem_rd_req),
    .mem_addr(mem_addr), .pc_out(pc_out), .ir_out(ir_out), .exec_phase(exec_phase)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // R3: fetch with optional wait cycles, then capture
  task automatic fetch_word(input logic [DW-1:0] w, input int waits);
    logic [DW-1:0] ir_before;
    ir_before = ir_out;
    for (int i = 0; i < waits; i++) begin
      mem_rdy = 1'b0; mem_rdata = ~w;
      @(negedge clk);
      chk("R2 phase", exec_phase, 1'b0);
      chk("R2 pc", pc_out, exp_pc);
      chk("R2 ir", ir_out, ir_before);
    end
    mem_rdy = 1'b1; mem_rdata = w;
    @(negedge clk);
    mem_rdy = 1'b0;
    chk("R3 ir", ir_out, w);
    chk("R3 exec", exec_phase, 1'b1);
    chk("R8 rd_req", mem_rd_req, 1'b0);
  endtask

  // R5/R6/R7: one execute cycle
  task automatic exec_step(input logic br, input logic [OW-1:0] off, input logic z,
                           input logic n, input string req);
    logic take;
    take = br && !z && !n;
    br_req = br; br_off = off; flag_z = z; flag_n = n;
    exp_pc = exp_pc + 32'd4 + (take ? AW'($signed(off)) : 32'd0);
    @(negedge clk);
    br_req = 1'b0; br_off = '0; flag_z = 1'b0; flag_n = 1'b0;
    chk(req, pc_out, exp_pc);
    chk("R4 back to fetch", exec_phase, 1'b0);
    chk("R8 addr", mem_addr, exp_pc);
    chk("R8 rd_req", mem_rd_req, 1'b1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mem_rdy = 1'b0; mem_rdata = '0; br_req = 1'b0; br_off = '0;
    flag_z = 1'b0; flag_n = 1'b0; exp_pc = START;
    repeat (3) @(negedge clk);
    chk("R1 pc", pc_out, START);
    chk("R1 ir", ir_out, '0);
    chk("R1 phase", exec_phase, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 rd_req", mem_rd_req, 1'b1);
    chk("R1 pc after release", pc_out, START);
  endtask

  task automatic t_fetch_ignores_branch();
    mem_rdy = 1'b0; br_req = 1'b1; br_off = 16'hFFF0;
    repeat (3) @(negedge clk);
    chk("R2 branch ignored in fetch", pc_out, exp_pc);
    br_req = 1'b0; br_off = '0;
  endtask

  task automatic t_loop();
    // straight line from 1000 to 1012, then loop back with -16 (R6)
    fetch_word(32'hA000_0001, 2); exec_step(1'b0, '0, 1'b0, 1'b0, "R5 seq");
    chk("R5 1004", pc_out, 32'd1004);
    fetch_word(32'hA000_0002, 0); exec_step(1'b0, '0, 1'b0, 1'b0, "R5 seq");
    fetch_word(32'hA000_0003, 1); exec_step(1'b0, '0, 1'b0, 1'b0, "R5 seq");
    fetch_word(32'hB000_0004, 0); exec_step(1'b1, 16'hFFF0, 1'b0, 1'b0, "R6 back");
    chk("R6 loop head", pc_out, 32'd1000);
  endtask

  task automatic t_not_taken();
    fetch_word(32'hC000_0001, 0); exec_step(1'b1, 16'hFFF0, 1'b1, 1'b0, "R7 zero");
    chk("R7 zero falls", pc_out, 32'd1004);
    fetch_word(32'hC000_0002, 0); exec_step(1'b1, 16'hFFF0, 1'b0, 1'b1, "R7 neg");
    chk("R7 neg falls", pc_out, 32'd1008);
  endtask

  task automatic t_forward_and_exec_ignore();
    fetch_word(32'hD000_0001, 0);
    // R9: ready and data during execute must not reload the register
    mem_rdy = 1'b1; mem_rdata = 32'hDEAD_BEEF;
    exec_step(1'b1, 16'd8, 1'b0, 1'b0, "R6 fwd");
    mem_rdy = 1'b0;
    chk("R9 ir held", ir_out, 32'hD000_0001);
    chk("R6 fwd target", pc_out, 32'd1020);
  endtask

  task automatic t_wrap();
    fetch_word(32'hE000_0001, 0);
    exec_step(1'b1, 16'h8000, 1'b0, 1'b0, "R10 wrap");
    chk("R10 wrapped", pc_out, 32'hFFFF_8400);
  endtask

  initial begin
    t_reset();
    t_fetch_ignores_branch();
    t_loop();
    t_not_taken();
    t_forward_and_exec_ignore();
    t_wrap();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule